// File: doc/BRIEF.md
# Chaos-Keyed Bit Stream Scrambler

This block hides a serial bit stream by XORing every accepted data bit with a key bit. The key comes from two fixed-point logistic-map iterators, x' = r·x·(1−x). Each iterator starts from its own seed. On every accepted bit both iterators take one step. The key bit is the result of comparing their two states.

Because XOR undoes itself, the receiving side uses an identical instance with the same parameters. When both are restarted at the same moment, the receiver turns the scrambled stream back into the original one. A synchronous restart input reloads both seeds, so a link can realign its two ends at frame boundaries. The map parameter r and the two seeds are elaboration parameters.

Top module: `chaos_scrambler`

## Requirements
- R1: `out_valid` is `in_valid` delayed by one clock. It is forced low in the cycle after `rst` or `restart` was high.
- R2: A bit accepted with `in_valid` high appears one clock later on `out_bit` as `in_bit ^ key`. `key` is 1 when map A's state is strictly greater than map B's state, and 0 otherwise. The states used are the ones in place when the bit is accepted.
- R3: Each state is an unsigned 1.31 fraction (32 bits, value/2^31). The map parameter is unsigned 4.28. One step works as follows:
  - p = (x·(2^31−x)) >> 31, truncated to 32 bits.
  - x' = (r·p) >> 28, truncated to 32 bits.
- R4: Both states hold when `in_valid` is low. Idle cycles between valid bits do not change the key sequence.
- R5: `restart` reloads both seeds. A bit presented in the same cycle as `restart` is dropped: there is no output for it and no state step. The next accepted bit uses key 0 of the sequence again.
- R6: After `rst` the outputs are low and both maps hold their seeds. The first accepted bit uses the key computed from the seeds.
- R7: A step result of 0 is replaced by 1 (one LSB), and a result of 2^31 or more is replaced by 2^31−1. Every state therefore stays in [1, 2^31−1].
- R8: A descrambler instance fed by a scrambler's outputs, with the same parameters and restarted together with it, returns the original bit sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| restart | input | 1 | Synchronous reload of both seeds, active high |
| in_valid | input | 1 | Qualifies `in_bit`; each high cycle consumes one key bit |
| in_bit | input | 1 | Data bit to scramble or descramble |
| out_valid | output | 1 | Qualifies `out_bit`, one cycle after `in_valid` |
| out_bit | output | 1 | Input bit XOR key bit |

## Verification
The hardest behaviour to reach from the ports is the saturation of R7. With the default r and seeds, a state never lands on 0 or 1.

The bench therefore builds a second instance with r = 4.0 and a map-A seed of exactly 0.5. Its first step produces exactly 1.0, which must be pulled down to 2^31−1. The step after that produces 0, which must be lifted to one LSB. The key bits of that instance are then compared with a bench-side fixed-point model.

The keystream ordering under idle gaps, and a restart that collides with a valid bit, are each driven by a dedicated directed task.

// File: rtl/chaos_pkg.sv
package chaos_pkg;
   // Default 1.31 seeds (about 0.939243 and 0.162343) and 4.28 map parameter (about 3.99)
   localparam int unsigned       DEF_STATE_W = 32;
   localparam int unsigned       DEF_R_W     = 32;
   localparam int unsigned       DEF_R_FRAC  = 28;
   localparam longint unsigned   DEF_MAP_R   = 64'd1071057469;
   localparam longint unsigned   DEF_SEED_A  = 64'd2017008984;
   localparam longint unsigned   DEF_SEED_B  = 64'd348628938;
   localparam int unsigned       NUM_MAPS    = 2;
endpackage

// File: rtl/logistic_iter.sv
module logistic_iter #(
   parameter int unsigned     STATE_W = chaos_pkg::DEF_STATE_W,
   parameter int unsigned     R_W     = chaos_pkg::DEF_R_W,
   parameter int unsigned     R_FRAC  = chaos_pkg::DEF_R_FRAC,
   parameter longint unsigned MAP_R   = chaos_pkg::DEF_MAP_R,
   parameter longint unsigned SEED    = chaos_pkg::DEF_SEED_A
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               restart,
   input  logic               advance,
   output logic [STATE_W-1:0] state
);
   localparam int unsigned        FRAC   = STATE_W - 1;
   localparam logic [STATE_W-1:0] ONE    = STATE_W'(1) << FRAC;
   localparam logic [STATE_W-1:0] TOP    = ONE - STATE_W'(1);
   localparam logic [STATE_W-1:0] SEED_V = STATE_W'(SEED);
   localparam logic [R_W-1:0]     R_V    = R_W'(MAP_R);

   // x * (1 - x) in 1.FRAC, truncated
   function automatic logic [STATE_W-1:0] quad(input logic [STATE_W-1:0] x);
      logic [2*STATE_W-1:0] wide;
      wide = {{STATE_W{1'b0}}, x} * {{STATE_W{1'b0}}, ONE - x};
      return wide[FRAC +: STATE_W];
   endfunction

   // r * p, rescaled from R_FRAC+FRAC fraction bits back to FRAC
   function automatic logic [STATE_W-1:0] scale(input logic [STATE_W-1:0] p);
      logic [R_W+STATE_W-1:0] wide;
      wide = {{STATE_W{1'b0}}, R_V} * {{R_W{1'b0}}, p};
      return wide[R_FRAC +: STATE_W];
   endfunction

   logic [STATE_W-1:0] raw;
   logic [STATE_W-1:0] nxt;

   assign raw = scale(quad(state));

   always_comb begin
      nxt = raw;
      if (raw == '0)
         nxt = STATE_W'(1);
      else if (raw >= ONE)
         nxt = TOP;
   end

   always_ff @(posedge clk) begin
      if (rst || restart)
         state <= SEED_V;
      else if (advance)
         state <= nxt;
   end
endmodule

// File: rtl/chaos_state_pair.sv
module chaos_state_pair #(
   parameter int unsigned     STATE_W = chaos_pkg::DEF_STATE_W,
   parameter int unsigned     R_W     = chaos_pkg::DEF_R_W,
   parameter int unsigned     R_FRAC  = chaos_pkg::DEF_R_FRAC,
   parameter longint unsigned MAP_R   = chaos_pkg::DEF_MAP_R,
   parameter longint unsigned SEED_A  = chaos_pkg::DEF_SEED_A,
   parameter longint unsigned SEED_B  = chaos_pkg::DEF_SEED_B
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               restart,
   input  logic               advance,
   output logic [STATE_W-1:0] state_a,
   output logic [STATE_W-1:0] state_b
);
   localparam int unsigned N = chaos_pkg::NUM_MAPS;

   logic [STATE_W-1:0] st [N];

   for (genvar g = 0; g < N; g++) begin : g_map
      localparam longint unsigned SEED_G = (g == 0) ? SEED_A : SEED_B;
      logistic_iter #(
         .STATE_W(STATE_W), .R_W(R_W), .R_FRAC(R_FRAC),
         .MAP_R(MAP_R), .SEED(SEED_G)
      ) u_iter (
         .clk(clk), .rst(rst), .restart(restart),
         .advance(advance), .state(st[g])
      );
   end

   assign state_a = st[0];
   assign state_b = st[1];
endmodule

// File: rtl/chaos_scrambler.sv
module chaos_scrambler #(
   parameter int unsigned     STATE_W = chaos_pkg::DEF_STATE_W,
   parameter int unsigned     R_W     = chaos_pkg::DEF_R_W,
   parameter int unsigned     R_FRAC  = chaos_pkg::DEF_R_FRAC,
   parameter longint unsigned MAP_R   = chaos_pkg::DEF_MAP_R,
   parameter longint unsigned SEED_A  = chaos_pkg::DEF_SEED_A,
   parameter longint unsigned SEED_B  = chaos_pkg::DEF_SEED_B
) (
   input  logic clk,
   input  logic rst,
   input  logic restart,
   input  logic in_valid,
   input  logic in_bit,
   output logic out_valid,
   output logic out_bit
);
   localparam longint unsigned ONE_L = 64'd1 << (STATE_W - 1);
   localparam longint unsigned R_MAX = 64'd4 << R_FRAC;

   // Elaboration-time parameter checks
   if (STATE_W < 8 || STATE_W > 32) begin : g_bad_width
      $error("chaos_scrambler: STATE_W must lie in 8..32");
   end
   if (R_FRAC >= R_W || R_W > 32) begin : g_bad_rfmt
      $error("chaos_scrambler: R_FRAC must be below R_W and R_W at most 32");
   end
   if (MAP_R == 0 || MAP_R > R_MAX) begin : g_bad_r
      $error("chaos_scrambler: MAP_R must lie in (0, 4.0]");
   end
   if (SEED_A == 0 || SEED_A >= ONE_L || SEED_B == 0 || SEED_B >= ONE_L) begin : g_bad_seed
      $error("chaos_scrambler: seeds must lie strictly between 0 and 1");
   end

   logic [STATE_W-1:0] state_a;
   logic [STATE_W-1:0] state_b;
   logic               key;
   logic               accept;

   assign accept = in_valid && !restart;
   assign key    = state_a > state_b;

   chaos_state_pair #(
      .STATE_W(STATE_W), .R_W(R_W), .R_FRAC(R_FRAC),
      .MAP_R(MAP_R), .SEED_A(SEED_A), .SEED_B(SEED_B)
   ) u_pair (
      .clk(clk), .rst(rst), .restart(restart), .advance(accept),
      .state_a(state_a), .state_b(state_b)
   );

   always_ff @(posedge clk) begin
      if (rst || restart) begin
         out_valid <= 1'b0;
         out_bit   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid)
            out_bit <= in_bit ^ key;
      end
   end
endmodule

// File: rtl/chaos_scrambler_chk.sv
module chaos_scrambler_chk #(
   parameter int unsigned     STATE_W = 32,
   parameter longint unsigned SEED_A  = 1,
   parameter longint unsigned SEED_B  = 1
) (
   input logic               clk,
   input logic               rst,
   input logic               restart,
   input logic               in_valid,
   input logic               in_bit,
   input logic               out_valid,
   input logic               out_bit,
   input logic [STATE_W-1:0] state_a,
   input logic [STATE_W-1:0] state_b
);
   localparam logic [STATE_W-1:0] ONE = STATE_W'(1) << (STATE_W - 1);
   localparam logic [STATE_W-1:0] SA  = STATE_W'(SEED_A);
   localparam logic [STATE_W-1:0] SB  = STATE_W'(SEED_B);

   a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !restart) |=> out_valid);
   a_r1_valid_idle: assert property (@(posedge clk) disable iff (rst)
      (!in_valid || restart) |=> !out_valid);
   a_r2_xor_key: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !restart) |=> (out_bit == ($past(in_bit) ^ ($past(state_a) > $past(state_b)))));
   a_r4_hold: assert property (@(posedge clk) disable iff (rst)
      (!in_valid && !restart) |=> ($stable(state_a) && $stable(state_b)));
   a_r5_reload: assert property (@(posedge clk) disable iff (rst)
      restart |=> (state_a == SA && state_b == SB && !out_valid));
   a_r6_reset: assert property (@(posedge clk)
      rst |=> (!out_valid && !out_bit && state_a == SA && state_b == SB));
   a_r7_in_range: assert property (@(posedge clk) disable iff (rst)
      (state_a != '0 && state_a < ONE && state_b != '0 && state_b < ONE));
endmodule

bind chaos_scrambler chaos_scrambler_chk #(
   .STATE_W(STATE_W), .SEED_A(SEED_A), .SEED_B(SEED_B)
) u_chk (
   .clk(clk), .rst(rst), .restart(restart), .in_valid(in_valid),
   .in_bit(in_bit), .out_valid(out_valid), .out_bit(out_bit),
   .state_a(state_a), .state_b(state_b)
);

// File: tb/tb_chaos_scrambler.sv
`timescale 1ns/1ps
module tb_chaos_scrambler;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic restart = 1'b0;
   logic in_valid = 1'b0;
   logic in_bit = 1'b0;
   logic out_valid, out_bit;
   logic rx_valid, rx_bit;
   logic e_valid, e_bit;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   chaos_scrambler dut (
      .clk(clk), .rst(rst), .restart(restart), .in_valid(in_valid),
      .in_bit(in_bit), .out_valid(out_valid), .out_bit(out_bit));

   chaos_scrambler rx (
      .clk(clk), .rst(rst), .restart(restart), .in_valid(out_valid),
      .in_bit(out_bit), .out_valid(rx_valid), .out_bit(rx_bit));

   chaos_scrambler #(
      .MAP_R(64'd1 << 30), .SEED_A(64'd1 << 30), .SEED_B(64'd1 << 29)
   ) dut_edge (
      .clk(clk), .rst(rst), .restart(restart), .in_valid(in_valid),
      .in_bit(in_bit), .out_valid(e_valid), .out_bit(e_bit));

   // Fixed-point model of one map step, written from R3 and R7
   function automatic longint unsigned ref_step(longint unsigned x, longint unsigned r);
      longint unsigned one, p, raw;
      one = 64'd1 << 31;
      p   = ((x * (one - x)) >> 31) & 64'hFFFF_FFFF;
      raw = ((r * p) >> 28) & 64'hFFFF_FFFF;
      if (raw == 0) raw = 1;
      else if (raw >= one) raw = one - 1;
      return raw;
   endfunction

   bit key_d [32];
   bit key_e [16];

   task automatic build_keys();
      longint unsigned a, b;
      a = chaos_pkg::DEF_SEED_A; b = chaos_pkg::DEF_SEED_B;
      for (int i = 0; i < 32; i++) begin
         key_d[i] = (a > b);
         a = ref_step(a, chaos_pkg::DEF_MAP_R);
         b = ref_step(b, chaos_pkg::DEF_MAP_R);
      end
      a = 64'd1 << 30; b = 64'd1 << 29;
      for (int i = 0; i < 16; i++) begin
         key_e[i] = (a > b);
         a = ref_step(a, 64'd1 << 30);
         b = ref_step(b, 64'd1 << 30);
      end
   endtask

   task automatic check_bit(string tag, logic act, logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   // Drive at a falling edge, let one rising edge pass, stop at the next falling edge
   task automatic step(logic v, logic b, logic rs);
      in_valid = v; in_bit = b; restart = rs;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0; restart = 1'b0;
   endtask

   task automatic do_restart();
      step(1'b0, 1'b0, 1'b1);
      step(1'b0, 1'b0, 1'b0);
   endtask

   task automatic test_reset();
      check_bit("R6 out_valid after reset", out_valid, 1'b0);
      check_bit("R6 out_bit after reset", out_bit, 1'b0);
      step(1'b1, 1'b0, 1'b0);
      check_bit("R6 first key from seeds", out_bit, key_d[0]);
      check_bit("R1 valid after first bit", out_valid, 1'b1);
   endtask

   task automatic test_keystream();
      do_restart();
      for (int i = 0; i < 16; i++) begin
         step(1'b1, 1'b0, 1'b0);
         check_bit($sformatf("R3 key bit %0d", i), out_bit, key_d[i]);
      end
      do_restart();
      for (int i = 0; i < 8; i++) begin
         step(1'b1, 1'b1, 1'b0);
         check_bit($sformatf("R2 inverted key bit %0d", i), out_bit, ~key_d[i]);
      end
   endtask

   task automatic test_gaps();
      do_restart();
      for (int i = 0; i < 12; i++) begin
         step(1'b1, 1'b0, 1'b0);
         check_bit($sformatf("R4 key bit %0d with gaps", i), out_bit, key_d[i]);
         for (int g = 0; g < (i % 3) + 1; g++) begin
            step(1'b0, 1'b1, 1'b0);
            check_bit("R1 out_valid low in gap", out_valid, 1'b0);
         end
      end
   endtask

   task automatic test_restart_collision();
      do_restart();
      for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0);
      step(1'b1, 1'b0, 1'b1);
      check_bit("R5 bit with restart dropped", out_valid, 1'b0);
      for (int i = 0; i < 8; i++) begin
         step(1'b1, 1'b0, 1'b0);
         check_bit($sformatf("R5 key bit %0d after restart", i), out_bit, key_d[i]);
      end
   endtask

   task automatic test_roundtrip();
      bit sent [200];
      int rx_idx = 0;
      do_restart();
      for (int i = 0; i < 200; i++) begin
         sent[i] = 1'($urandom_range(0, 1));
         step(1'b1, sent[i], 1'b0);
         if (i < 32)
            check_bit($sformatf("R2 scrambled bit %0d", i), out_bit, sent[i] ^ key_d[i]);
         if (rx_valid) begin
            check_bit($sformatf("R8 recovered bit %0d", rx_idx), rx_bit, sent[rx_idx]);
            rx_idx++;
         end
      end
      for (int k = 0; k < 2; k++) begin
         step(1'b0, 1'b0, 1'b0);
         if (rx_valid) begin
            check_bit($sformatf("R8 recovered bit %0d", rx_idx), rx_bit, sent[rx_idx]);
            rx_idx++;
         end
      end
      n_checks++;
      if (rx_idx != 200) begin
         n_fail++;
         $display("FAIL R8 recovered count: actual %0d expected 200", rx_idx);
      end
   endtask

   task automatic test_saturation();
      bit exp_head [4] = '{1'b1, 1'b1, 1'b0, 1'b0};
      do_restart();
      for (int i = 0; i < 16; i++) begin
         step(1'b1, 1'b0, 1'b0);
         check_bit($sformatf("R7 saturated key bit %0d", i), e_bit, key_e[i]);
         if (i < 4)
            check_bit($sformatf("R7 hand-worked key bit %0d", i), e_bit, exp_head[i]);
      end
   endtask

   initial begin
      build_keys();
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      test_reset();
      test_keystream();
      test_gaps();
      test_restart_collision();
      test_roundtrip();
      test_saturation();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end
endmodule